// File: doc/BRIEF.md
# Single-Channel DMA Transfer Sequencer

This block drives one DMA channel. Software-side logic loads a source address, a destination address and a unit count, picks a configuration and pulses `start`. The sequencer then asks an external arbiter for the bus and moves data one unit at a time until the count runs out or an external terminate line falls. A unit is either one byte or one 16-bit word.

Four settings are independent, and every combination is legal. The data path is either memory-to-memory, where a read bus cycle fills an internal holding register and a separate write cycle empties it, or memory/I-O, where one bus cycle carries the unit directly between memory and a peripheral under an acknowledge strobe. The direction of a memory/I-O transfer is selectable. The unit size is byte or word. The pacing is either one unit per external request (cycle steal) or back-to-back units while the bus is held (burst).

In burst pacing the arbiter can ask for the bus back. A falling edge on the active-low terminate input can also end the job. Both take effect only once the unit in flight has finished. A release only pauses the job, and the next unit uses the following address. A terminate ends the job.

Top module: `dma_seq`

## Requirements
- R1: In memory-to-memory mode each unit is a read strobe (`bus_rd`) at the source address, followed in the very next cycle by a write strobe (`bus_wr`) at the destination address, with `io_ack` low in both. The write data equals the data read. For byte units bits 15:8 of the write data are zero.
- R2: In memory/I-O mode each unit is one bus cycle with `io_ack` high. With `cfg_io_to_mem` low that cycle is a `bus_rd` at the source address. With `cfg_io_to_mem` high it is a `bus_wr` at the destination address. `bus_rd` and `bus_wr` are never high together.
- R3: After each unit, the address used by that unit advances by 1 for byte units (`cfg_wide`=0) or by 2 for word units (`cfg_wide`=1). `bus_wide` shows the unit size during every strobe.
- R4: Each completed unit decrements the count. When it reaches zero, `busy` falls and `done` is high for exactly one cycle. A start with a count of zero produces `done` without any bus cycle.
- R5: In cycle-steal mode (`cfg_burst`=0) one unit is moved per cycle in which `dreq` is sampled high while the channel waits. `bus_req` drops after every unit.
- R6: In burst mode (`cfg_burst`=1) units follow one another with no gap, and `bus_req` stays high from the first grant to the end of the job.
- R7: In burst mode, a `bus_rel` sampled high at the end of a unit makes `bus_req` fall after that unit. The request is raised again once `bus_rel` is low, and the transfer resumes at the next address.
- R8: A high-to-low edge on `term_n` while busy ends the job at the next unit boundary, with a `done` pulse. A unit already started always completes. A level that stays low causes no further effect.
- R9: `start` while busy is ignored. Configuration, addresses and count are captured only when the channel is idle.
- R10: After reset the channel is idle: `busy`, `done`, `bus_req`, `bus_rd`, `bus_wr` and `io_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a job (ignored while busy) |
| cfg_one_cycle | input | 1 | 1: memory/I-O single-cycle path, 0: memory-to-memory |
| cfg_io_to_mem | input | 1 | Single-cycle direction, 1: I/O into memory |
| cfg_wide | input | 1 | 1: 16-bit units, 0: 8-bit units |
| cfg_burst | input | 1 | 1: burst pacing, 0: cycle steal |
| src_addr | input | AW | Initial source address |
| dst_addr | input | AW | Initial destination address |
| unit_count | input | CW | Number of units |
| dreq | input | 1 | Per-unit transfer request (cycle steal) |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_rel | input | 1 | Arbiter asks for the bus back (refresh/hold) |
| term_n | input | 1 | Active-low terminate, acted on at a falling edge |
| bus_addr | output | AW | Address of the current strobe, zero otherwise |
| bus_rd | output | 1 | Memory read strobe |
| bus_wr | output | 1 | Memory write strobe |
| bus_wide | output | 1 | Unit is 16 bits during a strobe |
| io_ack | output | 1 | Peripheral acknowledge for the single-cycle path |
| bus_rdata | input | 16 | Read data |
| bus_wdata | output | 16 | Write data from the holding register |
| busy | output | 1 | A job is active |
| done | output | 1 | One-cycle pulse when a job ends |

## Verification
A wrong pointer or step size shows on `bus_addr` at the very next strobe. A corrupted holding register shows on `bus_wdata` in the write cycle right after the read. A count that is off by one, or a terminate latch that is dropped or left set, moves the `done` pulse by at least one unit, which is two cycles in memory-to-memory mode. A wrong pacing decision shows as a `bus_req` edge one cycle after the unit boundary. The bench's behavioural model is compared every cycle, so each of these faults is reported within a few clocks of its cause.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_REQ,
        ST_RD,
        ST_WR,
        ST_IO
    } seq_state_e;

    typedef struct packed {
        logic one_cycle;
        logic io_to_mem;
        logic wide;
        logic burst;
    } seq_cfg_t;

endpackage

// File: rtl/dma_seq_path.sv
module dma_seq_path
    import dma_seq_pkg::*;
#(
    parameter int AW     = 16,
    parameter int CW     = 8,
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  seq_cfg_t            cfg_in,
    input  logic [AW-1:0]       src_in,
    input  logic [AW-1:0]       dst_in,
    input  logic [CW-1:0]       cnt_in,
    input  logic                src_step,
    input  logic                dst_step,
    input  logic                cnt_dec,
    input  logic                hold_ld,
    input  logic [2*BYTE_W-1:0] rdata,
    output seq_cfg_t            cfg_q,
    output logic [AW-1:0]       src_q,
    output logic [AW-1:0]       dst_q,
    output logic                cnt_zero,
    output logic                cnt_last,
    output logic [2*BYTE_W-1:0] hold_q
);
    localparam int DW = 2 * BYTE_W;

    typedef struct packed {
        seq_cfg_t      cfg;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
        logic [DW-1:0] hold;
    } path_t;

    path_t         r_q, r_d;
    logic [AW-1:0] step;

    always_comb begin
        step = {{(AW-2){1'b0}}, r_q.cfg.wide, ~r_q.cfg.wide};
        r_d  = r_q;
        if (load) begin
            r_d.cfg = cfg_in;
            r_d.src = src_in;
            r_d.dst = dst_in;
            r_d.cnt = cnt_in;
        end else begin
            if (src_step) r_d.src = r_q.src + step;
            if (dst_step) r_d.dst = r_q.dst + step;
            if (cnt_dec)  r_d.cnt = r_q.cnt - 1'b1;
            if (hold_ld)  r_d.hold = r_q.cfg.wide ? rdata
                                                  : {{BYTE_W{1'b0}}, rdata[BYTE_W-1:0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cfg_q    = r_q.cfg;
    assign src_q    = r_q.src;
    assign dst_q    = r_q.dst;
    assign hold_q   = r_q.hold;
    assign cnt_zero = (r_q.cnt == '0);
    assign cnt_last = (r_q.cnt == {{(CW-1){1'b0}}, 1'b1});

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       dreq,
    input  logic       bus_gnt,
    input  logic       bus_rel,
    input  logic       term_n,
    input  seq_cfg_t   cfg,
    input  logic       cnt_zero,
    input  logic       cnt_last,
    output seq_state_e state,
    output logic       load,
    output logic       src_step,
    output logic       dst_step,
    output logic       cnt_dec,
    output logic       hold_ld,
    output logic       done
);
    typedef struct packed {
        seq_state_e st;
        logic       term_prev;
        logic       pend;
        logic       done;
    } ctrl_t;

    ctrl_t      c_q, c_d;
    logic       busy_now, fall, hit;
    seq_state_e first_unit;

    always_comb begin
        c_d           = c_q;
        c_d.term_prev = term_n;
        c_d.done      = 1'b0;
        load          = 1'b0;
        busy_now      = (c_q.st != ST_IDLE);
        fall          = c_q.term_prev & ~term_n;
        hit           = c_q.pend | (fall & busy_now);
        first_unit    = cfg.one_cycle ? ST_IO : ST_RD;

        unique case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    load     = 1'b1;
                    c_d.st   = ST_ARM;
                end
            end
            ST_ARM: begin
                if (hit || cnt_zero) begin
                    c_d.st   = ST_IDLE;
                    c_d.done = 1'b1;
                end else if (cfg.burst ? !bus_rel : dreq) begin
                    c_d.st   = ST_REQ;
                end
            end
            ST_REQ: begin
                if (hit) begin
                    c_d.st   = ST_IDLE;
                    c_d.done = 1'b1;
                end else if (bus_gnt) begin
                    c_d.st   = first_unit;
                end
            end
            ST_RD: c_d.st = ST_WR;
            ST_WR, ST_IO: begin
                if (cnt_last || hit) begin
                    c_d.st   = ST_IDLE;
                    c_d.done = 1'b1;
                end else if (!cfg.burst || bus_rel) begin
                    c_d.st   = ST_ARM;
                end else begin
                    c_d.st   = first_unit;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase

        c_d.pend = hit & (c_d.st != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q           <= '0;
            c_q.term_prev <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign state    = c_q.st;
    assign done     = c_q.done;
    assign hold_ld  = (c_q.st == ST_RD);
    assign cnt_dec  = (c_q.st == ST_WR) || (c_q.st == ST_IO);
    assign src_step = (c_q.st == ST_RD) || ((c_q.st == ST_IO) && !cfg.io_to_mem);
    assign dst_step = (c_q.st == ST_WR) || ((c_q.st == ST_IO) && cfg.io_to_mem);

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          cfg_one_cycle,
    input  logic          cfg_io_to_mem,
    input  logic          cfg_wide,
    input  logic          cfg_burst,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    input  logic [CW-1:0] unit_count,
    input  logic          dreq,
    output logic          bus_req,
    input  logic          bus_gnt,
    input  logic          bus_rel,
    input  logic          term_n,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic          bus_wide,
    output logic          io_ack,
    input  logic [15:0]   bus_rdata,
    output logic [15:0]   bus_wdata,
    output logic          busy,
    output logic          done
);
    localparam int BYTE_W = 8;

    seq_state_e    state;
    seq_cfg_t      cfg_in, cfg_q;
    logic [AW-1:0] src_q, dst_q;
    logic [15:0]   hold_q;
    logic          load, src_step, dst_step, cnt_dec, hold_ld, cnt_zero, cnt_last;

    assign cfg_in = '{one_cycle: cfg_one_cycle, io_to_mem: cfg_io_to_mem,
                      wide: cfg_wide, burst: cfg_burst};

    dma_seq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .dreq     (dreq),
        .bus_gnt  (bus_gnt),
        .bus_rel  (bus_rel),
        .term_n   (term_n),
        .cfg      (cfg_q),
        .cnt_zero (cnt_zero),
        .cnt_last (cnt_last),
        .state    (state),
        .load     (load),
        .src_step (src_step),
        .dst_step (dst_step),
        .cnt_dec  (cnt_dec),
        .hold_ld  (hold_ld),
        .done     (done)
    );

    dma_seq_path #(.AW(AW), .CW(CW), .BYTE_W(BYTE_W)) u_path (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .cfg_in   (cfg_in),
        .src_in   (src_addr),
        .dst_in   (dst_addr),
        .cnt_in   (unit_count),
        .src_step (src_step),
        .dst_step (dst_step),
        .cnt_dec  (cnt_dec),
        .hold_ld  (hold_ld),
        .rdata    (bus_rdata),
        .cfg_q    (cfg_q),
        .src_q    (src_q),
        .dst_q    (dst_q),
        .cnt_zero (cnt_zero),
        .cnt_last (cnt_last),
        .hold_q   (hold_q)
    );

    always_comb begin
        busy      = (state != ST_IDLE);
        bus_req   = (state == ST_REQ) || (state == ST_RD) ||
                    (state == ST_WR)  || (state == ST_IO);
        io_ack    = (state == ST_IO);
        bus_rd    = (state == ST_RD) || (io_ack && !cfg_q.io_to_mem);
        bus_wr    = (state == ST_WR) || (io_ack && cfg_q.io_to_mem);
        bus_wide  = cfg_q.wide && (bus_rd || bus_wr);
        bus_addr  = '0;
        if (bus_rd)      bus_addr = src_q;
        else if (bus_wr) bus_addr = dst_q;
        bus_wdata = (state == ST_WR) ? hold_q : 16'h0000;
    end

endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_req,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic          bus_wide,
    input logic          io_ack,
    input logic [15:0]   bus_wdata,
    input logic          busy,
    input logic          done
);
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr)); // R2
    AST_IO_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        io_ack |-> (bus_rd || bus_wr)); // R2
    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !io_ack) |=> (bus_wr && !io_ack)); // R1
    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !io_ack) |-> $past(bus_rd && !io_ack)); // R1
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !io_ack && !bus_wide) |-> (bus_wdata[15:8] == 8'h00)); // R1
    AST_STROBE_HOLDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> (bus_req && busy)); // R5
    AST_UNIT_SIZE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && $past(bus_rd || bus_wr)) |-> $stable(bus_wide)); // R3
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R4
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req); // R10
endmodule

bind dma_seq dma_seq_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wide  (bus_wide),
    .io_ack    (io_ack),
    .bus_wdata (bus_wdata),
    .busy      (busy),
    .done      (done)
);

// File: tb/sim_dma_seq.sv
`timescale 1ns/1ps
module sim_dma_seq;
    localparam int AW = 16;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, cfg_one_cycle = 1'b0, cfg_io_to_mem = 1'b0;
    logic cfg_wide = 1'b0, cfg_burst = 1'b0;
    logic [AW-1:0] src_addr = '0, dst_addr = '0;
    logic [CW-1:0] unit_count = '0;
    logic dreq = 1'b0, bus_gnt = 1'b0, bus_rel = 1'b0, term_n = 1'b1;
    logic bus_req, bus_rd, bus_wr, bus_wide, io_ack, busy, done;
    logic [AW-1:0] bus_addr;
    logic [15:0] bus_rdata, bus_wdata;

    int n_chk = 0, n_fail = 0, cyc = 0;

    always #10 clk = ~clk;

    function automatic logic [15:0] pat(input logic [AW-1:0] a);
        return {a[7:0] ^ 8'hA5, a[7:0] + 8'h3C};
    endfunction

    assign bus_rdata = pat(bus_addr);

    dma_seq #(.AW(AW), .CW(CW)) u0 (.*);

    always @(posedge clk) bus_gnt <= rst_n && bus_req && !bus_rel;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference: phase 0 idle, 1 wait, 2 request, 3 read, 4 write, 5 single
    int ph = 0, m_cnt = 0, m_units = 0;
    bit m_one, m_io, m_wide, m_burst, m_done, m_tpend, m_tprev = 1;
    logic [AW-1:0] m_src, m_dst;
    logic [15:0] m_hold;

    always @(posedge clk) begin
        bit fall, th, fin;
        int stp;
        if (!rst_n) begin
            ph = 0; m_done = 0; m_tpend = 0; m_tprev = 1; m_cnt = 0;
        end else begin
            fall = m_tprev && !term_n;
            m_tprev = term_n;
            th = m_tpend || (fall && ph != 0);
            fin = 0;
            m_done = 0;
            stp = m_wide ? 2 : 1;
            case (ph)
                0: if (start) begin
                    m_one = cfg_one_cycle; m_io = cfg_io_to_mem;
                    m_wide = cfg_wide; m_burst = cfg_burst;
                    m_src = src_addr; m_dst = dst_addr; m_cnt = unit_count;
                    ph = 1;
                end
                1: if (th || m_cnt == 0) fin = 1;
                   else if (m_burst ? !bus_rel : dreq) ph = 2;
                2: if (th) fin = 1;
                   else if (bus_gnt) ph = m_one ? 5 : 3;
                3: begin
                    m_hold = m_wide ? pat(m_src) : {8'h00, pat(m_src)[7:0]};
                    m_src = m_src + AW'(stp);
                    ph = 4;
                end
                default: begin
                    if (ph == 5 && !m_io) m_src = m_src + AW'(stp);
                    else m_dst = m_dst + AW'(stp);
                    m_cnt--; m_units++;
                    if (m_cnt == 0 || th) fin = 1;
                    else if (!m_burst || bus_rel) ph = 1;
                    else ph = m_one ? 5 : 3;
                end
            endcase
            if (fin) begin ph = 0; m_done = 1; end
            m_tpend = th && ph != 0;
        end
    end

    int dut_units = 0, req_drops = 0;
    bit prev_req = 0;
    logic [AW-1:0] first_addr;
    bit got_first = 0;

    always @(negedge clk) if (rst_n) begin
        logic [AW-1:0] ea;
        bit er, ew;
        er = (ph == 3) || (ph == 5 && !m_io);
        ew = (ph == 4) || (ph == 5 && m_io);
        ea = er ? (ph == 3 || ph == 5 ? m_src : '0) : ew ? m_dst : '0;
        chk(bus_req == (ph >= 2), "R5 bus_req", bus_req, ph >= 2);
        chk(bus_rd == er && bus_wr == ew, "R1 strobes", {bus_rd, bus_wr}, {er, ew});
        chk(io_ack == (ph == 5), "R2 io_ack", io_ack, ph == 5);
        chk(bus_addr == ea, "R3 bus_addr", bus_addr, ea);
        if (er || ew) chk(bus_wide == m_wide, "R3 bus_wide", bus_wide, m_wide);
        if (ph == 4) chk(bus_wdata == m_hold, "R1 wdata", bus_wdata, m_hold);
        chk(busy == (ph != 0), "R9 busy", busy, ph != 0);
        chk(done == m_done, "R4 done", done, m_done);
        if ((bus_wr && !io_ack) || io_ack) dut_units++;
        if ((bus_rd || bus_wr) && !got_first) begin first_addr = bus_addr; got_first = 1; end
        if (prev_req && !bus_req) req_drops++;
        prev_req = bus_req;
    end

    task automatic run(input bit one, io, wide, burst, input int src, dst, cnt,
                       input int rel_from, rel_len, term_at, input bit restart);
        int k;
        @(negedge clk);
        cfg_one_cycle = one; cfg_io_to_mem = io; cfg_wide = wide; cfg_burst = burst;
        src_addr = AW'(src); dst_addr = AW'(dst); unit_count = CW'(cnt);
        dut_units = 0; m_units = 0; req_drops = 0; got_first = 0;
        start = 1;
        k = 0;
        while (1) begin
            @(negedge clk);
            k++;
            start = restart && (k == 3);
            if (start) begin src_addr = 16'hF000; unit_count = 8'd40; cfg_burst = 1; end
            dreq = (k % 5 == 2);
            bus_rel = (k >= rel_from) && (k < rel_from + rel_len);
            term_n = !(term_at >= 0 && k >= term_at);
            if (done) break;
            if (k > 3000) begin chk(0, "R4 job never ended", k, 0); break; end
        end
        dreq = 0; bus_rel = 0; start = 0;
        repeat (3) @(negedge clk);
        term_n = 1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !bus_req && !bus_rd && !bus_wr && !io_ack, "R10 reset idle",
            {busy, done, bus_req, bus_rd, bus_wr, io_ack}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        run(0, 0, 0, 0, 16'h0100, 16'h0200, 3, 9999, 0, -1, 0);
        chk(dut_units == 3, "R5 steal units", dut_units, 3);
        chk(req_drops == 3, "R5 bus dropped each unit", req_drops, 3);
        chk(first_addr == 16'h0100, "R1 first read at source", first_addr, 16'h0100);

        run(0, 0, 1, 1, 16'h0400, 16'h0800, 4, 9999, 0, -1, 0);
        chk(dut_units == 4, "R4 burst word units", dut_units, 4);
        chk(req_drops == 1, "R6 burst keeps bus", req_drops, 1);

        run(0, 0, 1, 1, 16'h1000, 16'h2000, 5, 6, 4, -1, 0);
        chk(dut_units == 5, "R7 units after release", dut_units, 5);
        chk(req_drops == 2, "R7 one pause", req_drops, 2);

        run(1, 0, 1, 1, 16'h3000, 16'h0000, 3, 9999, 0, -1, 0);
        chk(dut_units == 3, "R2 mem to io units", dut_units, 3);

        run(1, 1, 0, 0, 16'h0000, 16'h5000, 2, 9999, 0, -1, 0);
        chk(dut_units == 2, "R2 io to mem units", dut_units, 2);
        chk(first_addr == 16'h5000, "R2 io to mem uses destination", first_addr, 16'h5000);

        run(0, 0, 0, 1, 16'h6000, 16'h7000, 10, 9999, 0, 7, 0);
        chk(dut_units == m_units && dut_units > 0 && dut_units < 10, "R8 terminate early",
            dut_units, m_units);

        run(0, 1, 0, 0, 16'h0010, 16'h0020, 0, 9999, 0, -1, 0);
        chk(dut_units == 0, "R4 zero count no bus cycle", dut_units, 0);

        run(0, 0, 0, 0, 16'h0A00, 16'h0B00, 2, 9999, 0, -1, 1);
        chk(dut_units == 2, "R9 restart ignored", dut_units, 2);
        chk(first_addr == 16'h0A00, "R9 source kept", first_addr, 16'h0A00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL R4 watchdog expired actual=%0d expected=0", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule